// File: doc/BRIEF.md
# Clock-Change Watchdog Recovery Controller

This block watches over a software-driven change of the clock frequency-select code. A write of a new software code, or of a non-zero timeout, starts a countdown measured in seconds. Software confirms that the system is stable by writing a timeout of zero. If it does not do so before the countdown ends, the block treats the system as hung. It then sets a sticky alarm flag, reverts the active frequency code, and pulls the open-drain system reset line low for a fixed number of milliseconds.

A revert-mode bit chooses the code that applies after expiry. It can be the code latched from the hardware straps or the last code software wrote. An internal prescaler turns the core clock into millisecond and second ticks, so a simulation can shrink a second to a few dozen cycles. Every arming write restarts the prescaler, which makes the timeout a whole number of seconds measured from that write.

Top module: `wdr_ctrl`

## Requirements
- R1: After reset, `active_code` equals `strap_code`, `alarm` is 0, `srst_oe` is 0 and the stored timeout field is 0. The software code register resets to all zeros.
- R2: A cycle with `fsel_wr`=1 makes `active_code` equal to the written `fsel_val` from the next cycle on.
- R3: While the last written timeout value is 0, software code writes never cause an expiry. `alarm` and `srst_oe` stay 0.
- R4: With a stored timeout N (1 to 15), a software code write at clock edge W causes expiry at edge W + N·CLK_PER_MS·MS_PER_S and at no earlier edge. `alarm` reads 1 from that edge on.
- R5: A non-zero timeout write arms the timer. If the timer is already running, the write reloads the count, which is then measured from that write.
- R6: A timeout write of 0 before expiry stops the timer. No alarm and no reset follow, and `active_code` keeps the software code.
- R7: Once set, `alarm` stays 1 through software code writes and non-zero timeout writes. Only a timeout write of 0 returns it to 0, and it reads 0 from the next cycle.
- R8: The revert bit is sampled at the expiry edge. A value of 0 makes `active_code` follow `strap_code` from that edge. A value of 1 makes it hold the last software-written code.
- R9: `srst_oe` is 1 (the reset line is pulled low) for exactly PULSE_MS·CLK_PER_MS cycles, starting at the expiry edge. It is 0 at all other times, which leaves the line floating.
- R10: An expiry that occurs while a reset pulse is in progress neither restarts nor extends that pulse.
- R11: A timeout write or a software code write in the same cycle as the final second tick takes precedence, and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_wr | input | 1 | Write strobe for the timeout field |
| tmo_val | input | 4 | Timeout in seconds; 0 disables and clears the alarm |
| revert_sel | input | 1 | Code used after expiry: 0 = straps, 1 = last software code |
| fsel_wr | input | 1 | Write strobe for the software frequency code |
| fsel_val | input | 5 | Software frequency code |
| strap_code | input | 5 | Latched hardware strap code |
| active_code | output | 5 | Frequency-select code in force |
| alarm | output | 1 | Sticky expiry status |
| srst_oe | output | 1 | Open-drain enable; 1 pulls the system reset line low |

## Verification
The bench builds the block with CLK_PER_MS=4, MS_PER_S=5 and PULSE_MS=6. One second is then 20 cycles and the reset pulse is 24 cycles. With these values every timeout from 1 s to 15 s can be checked to the exact cycle. The pulse is also longer than one second, so a second expiry can be made to land inside a pulse that is still running, which exercises the no-retrigger rule. Random rounds vary the timeout, the codes, the revert bit and the point at which software confirms.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
    localparam int CODE_W = 5;
    localparam int TMO_W  = 4;

    typedef logic [CODE_W-1:0] fcode_t;
    typedef logic [TMO_W-1:0]  tmo_t;

    typedef enum logic {
        SRC_STRAP = 1'b0,
        SRC_SW    = 1'b1
    } fsrc_e;
endpackage

// File: rtl/wdr_prescale.sv
module wdr_prescale #(
    parameter int CLK_PER_MS = 100000,
    parameter int MS_PER_S   = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic sec_tick
);
    localparam int MS_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam int S_W  = (MS_PER_S > 1) ? $clog2(MS_PER_S) : 1;

    typedef struct packed {
        logic [MS_W-1:0] ms_cnt;
        logic [S_W-1:0]  s_cnt;
    } pre_t;

    pre_t st_d, st_q;
    logic ms_tick;

    assign ms_tick  = (st_q.ms_cnt == MS_W'(CLK_PER_MS - 1));
    assign sec_tick = ms_tick && (st_q.s_cnt == S_W'(MS_PER_S - 1));

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = '0;
        end else if (ms_tick) begin
            st_d.ms_cnt = '0;
            st_d.s_cnt  = sec_tick ? '0 : st_q.s_cnt + 1'b1;
        end else begin
            st_d.ms_cnt = st_q.ms_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdr_pulse.sv
module wdr_pulse #(
    parameter int PULSE_CYC = 600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pull
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic             on;
        logic [CNT_W-1:0] cnt;
    } pls_t;

    pls_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.on) begin
            // a fire request during a running pulse is dropped
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.on  = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (fire) begin
            st_d.on  = 1'b1;
            st_d.cnt = CNT_W'(PULSE_CYC);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pull = st_q.on;
endmodule

// File: rtl/wdr_ctrl.sv
module wdr_ctrl #(
    parameter int CLK_PER_MS = 100000,
    parameter int MS_PER_S   = 1000,
    parameter int PULSE_MS   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tmo_wr,
    input  logic [wdr_pkg::TMO_W-1:0]  tmo_val,
    input  logic                       revert_sel,
    input  logic                       fsel_wr,
    input  logic [wdr_pkg::CODE_W-1:0] fsel_val,
    input  logic [wdr_pkg::CODE_W-1:0] strap_code,
    output logic [wdr_pkg::CODE_W-1:0] active_code,
    output logic                       alarm,
    output logic                       srst_oe
);
    import wdr_pkg::*;

    localparam int PULSE_CYC = CLK_PER_MS * PULSE_MS;

    typedef struct packed {
        tmo_t   tmo;
        tmo_t   left;
        logic   run;
        logic   alarm;
        fsrc_e  src;
        fcode_t sw_code;
    } wd_t;

    wd_t  st_d, st_q;
    logic restart;
    logic expire;
    logic sec_tick;

    wdr_prescale #(
        .CLK_PER_MS (CLK_PER_MS),
        .MS_PER_S   (MS_PER_S)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .sec_tick (sec_tick)
    );

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        expire  = 1'b0;

        if (tmo_wr) begin
            st_d.tmo = tmo_val;
            if (tmo_val == '0) begin
                st_d.run   = 1'b0;
                st_d.alarm = 1'b0;
            end else begin
                st_d.run  = 1'b1;
                st_d.left = tmo_val;
                restart   = 1'b1;
            end
        end

        if (fsel_wr) begin
            st_d.sw_code = fsel_val;
            st_d.src     = SRC_SW;
            if (st_d.tmo != '0) begin
                st_d.run  = 1'b1;
                st_d.left = st_d.tmo;
                restart   = 1'b1;
            end
        end

        if (!tmo_wr && !fsel_wr && st_q.run && sec_tick) begin
            if (st_q.left == TMO_W'(1)) begin
                expire     = 1'b1;
                st_d.run   = 1'b0;
                st_d.left  = '0;
                st_d.alarm = 1'b1;
                st_d.src   = revert_sel ? SRC_SW : SRC_STRAP;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{tmo: '0, left: '0, run: 1'b0, alarm: 1'b0,
                      src: SRC_STRAP, sw_code: '0};
        end else begin
            st_q <= st_d;
        end
    end

    wdr_pulse #(
        .PULSE_CYC (PULSE_CYC)
    ) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (expire),
        .pull  (srst_oe)
    );

    assign active_code = (st_q.src == SRC_SW) ? st_q.sw_code : strap_code;
    assign alarm       = st_q.alarm;
endmodule

// File: rtl/wdr_ctrl_chk.sv
module wdr_ctrl_chk #(
    parameter int PULSE_CYC = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tmo_wr,
    input logic [3:0] tmo_val,
    input logic       revert_sel,
    input logic       fsel_wr,
    input logic [4:0] fsel_val,
    input logic [4:0] strap_code,
    input logic [4:0] active_code,
    input logic       alarm,
    input logic       srst_oe
);
    logic        off_q;
    int unsigned hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= 1'b1;
            hi_cnt <= 0;
        end else begin
            if (tmo_wr) off_q <= (tmo_val == 4'd0);
            hi_cnt <= srst_oe ? hi_cnt + 1 : 0;
        end
    end

    assert_code_applied_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fsel_wr |=> active_code == $past(fsel_val));

    assert_off_no_alarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        off_q |-> !alarm);

    assert_alarm_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm && !(tmo_wr && tmo_val == 4'd0) |=> alarm);

    assert_alarm_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_wr && tmo_val == 4'd0 |=> !alarm);

    assert_revert_strap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) && !$past(revert_sel) |-> active_code == strap_code);

    assert_pulse_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> srst_oe);

    assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_oe) |-> hi_cnt == PULSE_CYC);

    assert_no_stretch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_oe |-> hi_cnt < PULSE_CYC);
endmodule

bind wdr_ctrl wdr_ctrl_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmo_wr      (tmo_wr),
    .tmo_val     (tmo_val),
    .revert_sel  (revert_sel),
    .fsel_wr     (fsel_wr),
    .fsel_val    (fsel_val),
    .strap_code  (strap_code),
    .active_code (active_code),
    .alarm       (alarm),
    .srst_oe     (srst_oe)
);

// File: tb/sim_wdr_ctrl.sv
`timescale 1ns/1ps
module sim_wdr_ctrl;
    localparam int P   = 4;
    localparam int M   = 5;
    localparam int PMS = 6;
    localparam int S   = P * M;
    localparam int L   = P * PMS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmo_wr = 1'b0;
    logic [3:0] tmo_val = '0;
    logic       revert_sel = 1'b0;
    logic       fsel_wr = 1'b0;
    logic [4:0] fsel_val = '0;
    logic [4:0] strap_code = '0;
    logic [4:0] active_code;
    logic       alarm;
    logic       srst_oe;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    wdr_ctrl #(.CLK_PER_MS(P), .MS_PER_S(M), .PULSE_MS(PMS)) u0 (
        .clk(clk), .rst_n(rst_n), .tmo_wr(tmo_wr), .tmo_val(tmo_val),
        .revert_sel(revert_sel), .fsel_wr(fsel_wr), .fsel_val(fsel_val),
        .strap_code(strap_code), .active_code(active_code),
        .alarm(alarm), .srst_oe(srst_oe)
    );

    function automatic int exp_code(logic rev, logic [4:0] strap, logic [4:0] sw);
        return rev ? int'(sw) : int'(strap);
    endfunction

    function automatic int exp_cycles(int n);
        return n * S;
    endfunction

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_tmo(logic [3:0] v);
        tmo_val = v; tmo_wr = 1'b1;
        @(negedge clk);
        tmo_wr = 1'b0;
    endtask

    task automatic wr_fsel(logic [4:0] v);
        fsel_val = v; fsel_wr = 1'b1;
        @(negedge clk);
        fsel_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog R1..R11 run actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [4:0] c;
        void'($urandom(32'd4242));
        strap_code = 5'd19;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1 active_code", active_code, 19);
        chk("R1 alarm", alarm, 0);
        chk("R1 srst_oe", srst_oe, 0);

        // R2 / R3: timeout field is 0, code write never expires
        wr_fsel(5'd7);
        chk("R2 code applied", active_code, 7);
        idle(16 * S);
        chk("R3 no alarm when off", alarm, 0);
        chk("R3 no reset when off", srst_oe, 0);

        // R4 / R8 (revert to straps) / R9 pulse width
        revert_sel = 1'b0;
        wr_tmo(4'd2);
        wr_fsel(5'd11);
        idle(exp_cycles(2) - 1);
        chk("R4 alarm before expiry", alarm, 0);
        chk("R4 code before expiry", active_code, 11);
        idle(1);
        chk("R4 alarm at expiry", alarm, 1);
        chk("R8 revert to straps", active_code, exp_code(1'b0, strap_code, 5'd11));
        chk("R9 pulse starts", srst_oe, 1);
        idle(L - 1);
        chk("R9 pulse still low", srst_oe, 1);
        idle(1);
        chk("R9 pulse released", srst_oe, 0);
        wr_tmo(4'd3);
        chk("R7 alarm kept on nonzero write", alarm, 1);
        wr_tmo(4'd0);
        chk("R7 alarm cleared by zero write", alarm, 0);

        // R5 reload while running, R8 revert to software code
        revert_sel = 1'b1;
        wr_tmo(4'd3);
        wr_fsel(5'd22);
        idle(S);
        wr_tmo(4'd2);
        idle(exp_cycles(2) - 1);
        chk("R5 reload delays expiry", alarm, 0);
        idle(1);
        chk("R5 expiry after reload", alarm, 1);
        chk("R8 revert to sw code", active_code, exp_code(1'b1, strap_code, 5'd22));
        idle(L);
        wr_tmo(4'd0);

        // R6 confirm before expiry
        wr_tmo(4'd2);
        wr_fsel(5'd5);
        idle(S + 7);
        wr_tmo(4'd0);
        idle(3 * S);
        chk("R6 no alarm after confirm", alarm, 0);
        chk("R6 no reset after confirm", srst_oe, 0);
        chk("R6 code kept", active_code, 5);

        // R10 second expiry inside a running pulse
        revert_sel = 1'b1;
        wr_tmo(4'd1);
        wr_fsel(5'd9);
        idle(S - 1);
        chk("R10 alarm before first expiry", alarm, 0);
        idle(1);
        chk("R10 first expiry", srst_oe, 1);
        wr_fsel(5'd13);
        idle(S - 1);
        chk("R10 pulse before second expiry", srst_oe, 1);
        idle(1);
        chk("R10 second expiry keeps sw code", active_code, 13);
        idle(2);
        chk("R10 pulse not yet over", srst_oe, 1);
        idle(1);
        chk("R10 pulse not extended", srst_oe, 0);
        chk("R7 alarm still set", alarm, 1);
        wr_tmo(4'd0);

        // R11 write on the final tick wins
        wr_tmo(4'd1);
        wr_fsel(5'd3);
        idle(S - 1);
        wr_fsel(5'd30);
        chk("R11 no expiry on write cycle", alarm, 0);
        chk("R11 no reset on write cycle", srst_oe, 0);
        idle(S - 2);
        chk("R11 rearmed from write", alarm, 0);
        wr_tmo(4'd0);
        chk("R2 code from colliding write", active_code, 30);

        // random rounds
        for (int it = 0; it < 14; it++) begin
            int n;
            logic rev;
            strap_code = 5'($urandom_range(0, 31));
            c   = 5'($urandom_range(0, 31));
            n   = $urandom_range(1, 3);
            rev = 1'($urandom_range(0, 1));
            revert_sel = rev;
            wr_tmo(4'(n));
            wr_fsel(c);
            if ($urandom_range(0, 1) == 1) begin
                idle(exp_cycles(n) - 1);
                chk("R4 random pre-expiry", alarm, 0);
                idle(1);
                chk("R4 random expiry", alarm, 1);
                chk("R8 random revert", active_code, exp_code(rev, strap_code, c));
                idle(L);
                chk("R9 random release", srst_oe, 0);
                wr_tmo(4'd0);
                chk("R7 random clear", alarm, 0);
            end else begin
                idle($urandom_range(1, exp_cycles(n) - 2));
                wr_tmo(4'd0);
                idle(4 * S);
                chk("R6 random confirm", alarm, 0);
                chk("R6 random code kept", active_code, int'(c));
            end
        end

        finish_run();
    end
endmodule